// File: doc/BRIEF.md
# CPU Wait-State Clock Controller

This block puts a processor core into a low-power wait state and brings it back out. A one-cycle wait request from the core, which stands for the core's wait instruction, moves the controller out of the running state. A software-written mode bit picks the target state. Halt saves the most power and gives up cache snooping. Doze keeps snooping alive. A second software bit, the clock-stop bit, is armed ahead of time. If it is set when the wait request arrives, the core clock enable drops for as long as the low-power state lasts. Software clears the bit; hardware never does.

Any interrupt request that the interrupt-enable mask lets through wakes the core. The controller first passes through a one-cycle wake state with the clock enable already high, so the core's first run cycle is clocked. A core with every interrupt masked could never be woken. For that reason a wait request seen while the mask is all zeros is refused and a sticky error flag records it.

A small register port gives software access to the two control bits and to the error flag. The interrupt controller, the clock gating cell and the core pipeline sit outside this block.

Top module: `wait_clk_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the state output is RUN (code 0), clk_en is 1, snoop_en is 0, and the control register reads 0.
- R2: A wait request in RUN with a nonzero interrupt mask and halt_sel=1 makes state HALT (code 1) from the next cycle, with snoop_en 0.
- R3: The same request with halt_sel=0 makes state DOZE (code 2) from the next cycle. snoop_en is 1 exactly while the state is DOZE.
- R4: If clk_stop is 1 when an accepted wait request arrives, clk_en is 0 from the next cycle until the wake state. If clk_stop is 0, clk_en stays 1 throughout.
- R5: In HALT or DOZE, any bit set in both irq_req and irq_mask moves the state to WAKE (code 3) in the next cycle with clk_en 1 and snoop_en 0. The state is RUN one cycle later. Interrupt requests whose mask bit is 0 have no effect.
- R6: Hardware never changes halt_sel or clk_stop. They keep their written values across entry and wakeup until software writes again.
- R7: A wait request in RUN while irq_mask is all zeros is ignored: the state stays RUN and clk_en stays 1. It also sets the error flag (control bit 2), which stays 1 until reset.
- R8: A wait request while the state is not RUN has no effect on the state, clk_en or snoop_en.
- R9: A write to address 0 loads halt_sel from data bit 0 and clk_stop from data bit 1, effective the next cycle. Bit 2 (the error flag) is read-only. A read of address 0 returns {err, clk_stop, halt_sel} in bits 2..0 without delay. Writes to other addresses are ignored, and reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| wait_req | input | 1 | One-cycle wait request from the core |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_mask | input | NUM_IRQ | Interrupt enable mask, 1 = enabled |
| state | output | 2 | Current state: 0 RUN, 1 HALT, 2 DOZE, 3 WAKE |
| clk_en | output | 1 | Registered core clock enable |
| snoop_en | output | 1 | Snoop support active (doze) |

## Verification
The assertions expect every input to be synchronous to clk and stable around the rising edge. Reset must be held low for at least one edge before anything is checked. The bench changes all inputs on the falling edge, so each rising edge sees settled values. The random phase keeps the interrupt mask mostly nonzero, with zero masks mixed in so that refused waits occur. It also sends wait requests in every state, including while the core is asleep or waking.

// File: rtl/wait_pkg.sv
package wait_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_DOZE = 2'd2,
        ST_WAKE = 2'd3
    } wstate_t;

    typedef struct packed {
        logic halt_sel;
        logic clk_stop;
        logic err;
    } ctrl_t;

    typedef struct packed {
        wstate_t st;
        logic    clk_en;
        logic    snoop;
    } fsm_t;

endpackage

// File: rtl/wait_cfg_regs.sv
module wait_cfg_regs
    import wait_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              err_set,
    output logic              halt_sel,
    output logic              clk_stop
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    ctrl_t r_d, r_q;
    logic  hit;

    always_comb begin
        hit = (reg_addr == CTRL_A);
        r_d = r_q;
        if (reg_wr && hit) begin
            r_d.halt_sel = reg_wdata[0];
            r_d.clk_stop = reg_wdata[1];
        end
        if (err_set) r_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) reg_rdata[2:0] = {r_q.err, r_q.clk_stop, r_q.halt_sel};
    end

    assign halt_sel = r_q.halt_sel;
    assign clk_stop = r_q.clk_stop;

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);
    assert_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit) |=> ($stable(halt_sel) && $stable(clk_stop)));
    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> r_q.err);

endmodule

// File: rtl/wait_wake_detect.sv
module wait_wake_detect #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    output logic               wake,
    output logic               any_enabled
);

    logic [NUM_IRQ-1:0] live;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_gate
        assign live[i] = irq_req[i] & irq_mask[i];
    end

    assign wake        = |live;
    assign any_enabled = |irq_mask;

endmodule

// File: rtl/wait_fsm.sv
module wait_fsm
    import wait_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wait_req,
    input  logic    wake,
    input  logic    any_enabled,
    input  logic    halt_sel,
    input  logic    clk_stop,
    output wstate_t st,
    output logic    clk_en,
    output logic    snoop_en,
    output logic    refuse
);

    fsm_t f_d, f_q;

    always_comb begin
        f_d    = f_q;
        refuse = 1'b0;
        unique case (f_q.st)
            ST_RUN: begin
                if (wait_req) begin
                    if (any_enabled) begin
                        f_d.st     = halt_sel ? ST_HALT : ST_DOZE;
                        f_d.clk_en = !clk_stop;
                        f_d.snoop  = !halt_sel;
                    end else begin
                        refuse = 1'b1;
                    end
                end
            end
            ST_HALT, ST_DOZE: begin
                if (wake) begin
                    f_d.st     = ST_WAKE;
                    f_d.clk_en = 1'b1;
                    f_d.snoop  = 1'b0;
                end
            end
            ST_WAKE: f_d.st = ST_RUN;
            default: f_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '{st: ST_RUN, clk_en: 1'b1, snoop: 1'b0};
        else        f_q <= f_d;
    end

    assign st       = f_q.st;
    assign clk_en   = f_q.clk_en;
    assign snoop_en = f_q.snoop;

    assert_enter_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wait_req && any_enabled && halt_sel) |=> (st == ST_HALT && !snoop_en));
    assert_enter_doze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wait_req && any_enabled && !halt_sel) |=> (st == ST_DOZE && snoop_en));
    assert_snoop_doze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_en |-> st == ST_DOZE);
    assert_clk_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wait_req && any_enabled && clk_stop) |=> !clk_en);
    assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HALT || st == ST_DOZE) && wake) |=> (st == ST_WAKE && clk_en));
    assert_wake_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_WAKE |=> st == ST_RUN);
    assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wait_req && !any_enabled) |=> (st == ST_RUN && clk_en));
    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HALT || st == ST_DOZE) && !wake) |=> ($stable(st) && $stable(clk_en)));
    assert_run_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN || st == ST_WAKE) |-> clk_en);

endmodule

// File: rtl/wait_clk_ctrl.sv
module wait_clk_ctrl
    import wait_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               wait_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    output logic [1:0]         state,
    output logic               clk_en,
    output logic               snoop_en
);

    logic    halt_sel, clk_stop, refuse, wake, any_enabled;
    wstate_t st;

    wait_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_set(refuse),
        .halt_sel(halt_sel), .clk_stop(clk_stop)
    );

    wait_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_req(irq_req), .irq_mask(irq_mask),
        .wake(wake), .any_enabled(any_enabled)
    );

    wait_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wake(wake),
        .any_enabled(any_enabled), .halt_sel(halt_sel), .clk_stop(clk_stop),
        .st(st), .clk_en(clk_en), .snoop_en(snoop_en), .refuse(refuse)
    );

    assign state = st;

endmodule

// File: tb/wait_clk_ctrl_tb.sv
module wait_clk_ctrl_tb;

    localparam int NI = 8;
    localparam int AW = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          wait_req = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_mask = '0;
    logic [1:0]    state;
    logic          clk_en, snoop_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] m_st;
    logic m_clk, m_snoop, m_halt, m_stop, m_err;

    always #4 clk = ~clk;

    wait_clk_ctrl #(.NUM_IRQ(NI), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_req(wait_req),
        .irq_req(irq_req), .irq_mask(irq_mask), .state(state),
        .clk_en(clk_en), .snoop_en(snoop_en)
    );

    function automatic logic [DW-1:0] exp_rdata(input logic [AW-1:0] a);
        exp_rdata = '0;
        if (a == '0) exp_rdata[2:0] = {m_err, m_stop, m_halt};
    endfunction

    task automatic model_step();
        logic wk, mnz;
        wk  = |(irq_req & irq_mask);
        mnz = |irq_mask;
        if (!rst_n) begin
            m_st = 2'd0; m_clk = 1'b1; m_snoop = 1'b0;
            m_halt = 1'b0; m_stop = 1'b0; m_err = 1'b0;
            return;
        end
        case (m_st)
            2'd0: if (wait_req) begin
                if (mnz) begin
                    m_st = m_halt ? 2'd1 : 2'd2;
                    m_clk = !m_stop;
                    m_snoop = !m_halt;
                end else m_err = 1'b1;
            end
            2'd1, 2'd2: if (wk) begin
                m_st = 2'd3; m_clk = 1'b1; m_snoop = 1'b0;
            end
            default: m_st = 2'd0;
        endcase
        if (reg_wr && reg_addr == '0) begin
            m_halt = reg_wdata[0];
            m_stop = reg_wdata[1];
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (state !== m_st || clk_en !== m_clk || snoop_en !== m_snoop ||
            reg_rdata !== exp_rdata(reg_addr)) begin
            errors++;
            $display("FAIL %s: state=%0d clk_en=%0b snoop=%0b rdata=%h expected state=%0d clk_en=%0b snoop=%0b rdata=%h",
                     tag, state, clk_en, snoop_en, reg_rdata, m_st, m_clk, m_snoop, exp_rdata(reg_addr));
        end
    endtask

    task automatic cyc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic wq, input logic [NI-1:0] irq, input logic [NI-1:0] msk,
                       input string tag);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        wait_req = wq; irq_req = irq; irq_mask = msk;
        @(posedge clk);
        model_step();
        @(negedge clk);
        reg_wr = 1'b0; wait_req = 1'b0;
        compare(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        repeat (3) cyc(1'b0, '0, '0, 1'b0, '0, '0, "R1");
        rst_n = 1'b1;
        cyc(1'b0, '0, '0, 1'b0, '0, 8'hFF, "R1");
        // R9: write halt_sel=1, clk_stop=0
        cyc(1'b1, 2'd0, 8'h01, 1'b0, '0, 8'hFF, "R9");
        // R2 / R4: enter halt with clock on
        cyc(1'b0, 2'd0, '0, 1'b1, '0, 8'hFF, "R2");
        // R8: wait request while asleep
        cyc(1'b0, 2'd0, '0, 1'b1, '0, 8'h0F, "R8");
        // R5: request on a masked line does nothing
        cyc(1'b0, 2'd0, '0, 1'b0, 8'hF0, 8'h0F, "R5");
        cyc(1'b0, 2'd0, '0, 1'b0, 8'h01, 8'h0F, "R5");
        cyc(1'b0, 2'd0, '0, 1'b1, '0, 8'h0F, "R8");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h0F, "R5");
        // R3 / R4: doze with clock stopped
        cyc(1'b1, 2'd0, 8'h02, 1'b0, '0, 8'h0F, "R9");
        cyc(1'b0, 2'd0, '0, 1'b1, '0, 8'h0F, "R3");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h0F, "R4");
        cyc(1'b0, 2'd0, '0, 1'b0, 8'h08, 8'h0F, "R5");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h0F, "R5");
        // R6: bits unchanged after wakeup
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h0F, "R6");
        // R7: refused wait, sticky error
        cyc(1'b0, 2'd0, '0, 1'b1, '0, 8'h00, "R7");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h00, "R7");
        cyc(1'b1, 2'd0, 8'h00, 1'b0, '0, 8'h01, "R7");
        // R9: other address ignored on write, reads zero
        cyc(1'b1, 2'd1, 8'h03, 1'b0, '0, 8'h01, "R9");
        cyc(1'b0, 2'd1, '0, 1'b0, '0, 8'h01, "R9");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h01, "R9");
        // R2 again with clock stop, wake on highest line
        cyc(1'b1, 2'd0, 8'h03, 1'b0, '0, 8'h80, "R9");
        cyc(1'b0, 2'd0, '0, 1'b1, 8'h80, 8'h80, "R2");
        cyc(1'b0, 2'd0, '0, 1'b0, 8'h80, 8'h80, "R5");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 8'h80, "R5");
        // random phase covering R8 and the rest
        for (int i = 0; i < 4000; i++) begin
            logic          wr, wq;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [NI-1:0] irq, msk;
            wr  = ($urandom % 8) == 0;
            a   = AW'($urandom % 4);
            d   = DW'($urandom);
            wq  = ($urandom % 4) == 0;
            irq = (($urandom % 5) == 0) ? NI'(1 << ($urandom % NI)) : '0;
            msk = (($urandom % 10) == 0) ? '0 : NI'($urandom);
            cyc(wr, a, d, wq, irq, msk, "R8");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule